// File: doc/BRIEF.md
# Three-Level Phase Leg Gate Sequencer

This block produces the four gate drives of one leg of a three-level inverter. The gates form an upper pair (outer A, inner B) and a lower pair (inner A, outer B). Two compare values are each weighed against their own carrier. The result of the two comparisons picks a leg state: upper pair conducting, lower pair conducting, or all four gates forced off.

Each change of leg state passes through a two-state sequencer with a ready state and a wait state. When a change is due, the gates being released are cleared first. A dead-time counter is loaded from the `dead_cycles` input. The arriving gates are switched on only when the counter has run out. Carrier generation and fault tripping sit outside this block.

Gate vectors below are written {gate_up_a, gate_up_b, gate_lo_a, gate_lo_b}, so 4'b1100 is upper pair on and 4'b0011 is lower pair on. "Upper pattern" means both compares are below their carriers. "Lower pattern" means both are above. "Off pattern" means compare_a < carrier_a and compare_b > carrier_b.

Top module: `tl_leg_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, all four gates become 0 and the sequencer returns to its ready state with a zero counter.
- R2: With compare_a < carrier_a and compare_b < carrier_b held, the leg settles at gates 4'b1100.
- R3: With compare_a > carrier_a and compare_b > carrier_b held, the leg settles at gates 4'b0011.
- R4: With the off pattern present at an edge, all four gates are 0 after that edge. The sequencer state and the counter hold their values, so an interrupted dead time resumes where it stopped.
- R5: Any other compare relation, including equality of a compare with its carrier, acts as the upper pattern (target 4'b1100).
- R6: When the sequencer is ready and the target pair is not fully on, the departing pair is cleared at the next edge. With dead_cycles = D sampled at that edge, the target pair turns on at the (D+1)-th edge counted from that edge. With D = 0 the target pair turns on at the first edge.
- R7: The dead time is the dead_cycles value sampled at the edge that starts the wait. Changing dead_cycles during the wait has no effect on when the gates turn on.
- R8: Gate gate_up_a is never 1 together with either lower gate, and gate_lo_b is never 1 together with either upper gate.
- R9: Once the target pair is on and the inputs are held, the gates stay unchanged and no new dead time starts.
- R10: If the pattern changes during a wait, the gates at the end of the wait follow the pattern present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| carrier_a | input | CW | Carrier for the first comparison |
| compare_a | input | CW | Compare value for the first comparison |
| carrier_b | input | CW | Carrier for the second comparison |
| compare_b | input | CW | Compare value for the second comparison |
| dead_cycles | input | DW | Dead-time length in clock cycles |
| gate_up_a | output | 1 | Upper pair, outer switch |
| gate_up_b | output | 1 | Upper pair, inner switch |
| gate_lo_a | output | 1 | Lower pair, inner switch |
| gate_lo_b | output | 1 | Lower pair, outer switch |

## Verification
Suppose the sequencer enters wait at the wrong time, or the counter is loaded or decremented wrongly. The gates then switch on one or more edges away from the (D+1)-th edge after a change. Such a slip shows at the ports within a single dead-time window.

Suppose the off pattern fails to freeze the counter. The resumed wait then ends early, visible the edge after the pattern returns. A wrong clear mask shows up at once as overlapping pair conduction, or as a departing gate still high during the wait.

// File: rtl/tl_leg_pkg.sv
// Shared types for the three-level leg gate sequencer.
// Assumes gate vectors are ordered {up_a, up_b, lo_a, lo_b}, MSB first.
package tl_leg_pkg;

    // Leg state from the comparators: bit 1 is the first line, bit 0 the second.
    typedef enum logic [1:0] {
        LEG_NEUTRAL = 2'b00,
        LEG_UPPER   = 2'b01,
        LEG_LOWER   = 2'b10,
        LEG_OFF     = 2'b11
    } leg_line_e;

    typedef enum logic {
        SEQ_READY = 1'b0,
        SEQ_WAIT  = 1'b1
    } seq_state_e;

    localparam int unsigned GATE_N = 4;

endpackage

// File: rtl/tl_leg_line_decode.sv
// Compares two compare/carrier pairs and maps the outcome onto a leg state.
// Assumes unsigned operands; equality falls into the default upper state.
module tl_leg_line_decode
    import tl_leg_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic [CW-1:0] carrier_a,
    input  logic [CW-1:0] compare_a,
    input  logic [CW-1:0] carrier_b,
    input  logic [CW-1:0] compare_b,
    output leg_line_e     leg_line
);
    localparam int unsigned NCMP = 2;

    logic [NCMP-1:0][CW-1:0] car_v;
    logic [NCMP-1:0][CW-1:0] cmp_v;
    logic [NCMP-1:0]         below;
    logic [NCMP-1:0]         above;

    assign car_v = {carrier_b, carrier_a};
    assign cmp_v = {compare_b, compare_a};

    // One magnitude comparator per compare/carrier pair.
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign below[i] = cmp_v[i] < car_v[i];
        assign above[i] = cmp_v[i] > car_v[i];
    end

    // Priority mapping of comparison outcomes to the leg state.
    always_comb begin
        if (below[0] && below[1]) begin
            leg_line = LEG_UPPER;
        end else if (above[0] && above[1]) begin
            leg_line = LEG_LOWER;
        end else if (below[0] && above[1]) begin
            leg_line = LEG_OFF;
        end else begin
            leg_line = LEG_UPPER;
        end
    end
endmodule

// File: rtl/tl_leg_gate_seq.sv
// Ready/wait dead-time sequencer for the four gates of one leg.
// Assumes leg_line may change on any cycle; LEG_OFF clears the gates and
// freezes the state and counter. Dead time is sampled when a wait starts.
module tl_leg_gate_seq
    import tl_leg_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  leg_line_e           leg_line,
    input  logic [DW-1:0]       dead_cycles,
    output logic [GATE_N-1:0]   gates,
    output seq_state_e          state,
    output logic [DW-1:0]       count
);
    logic [GATE_N-1:0] trig_mask_n;
    logic [GATE_N-1:0] clr_mask;
    logic [GATE_N-1:0] target;
    logic              trig;

    logic [GATE_N-1:0] gates_nx;
    seq_state_e        state_nx;
    logic [DW-1:0]     count_nx;

    // Per-state target pattern, clear mask and the gates whose absence starts a change.
    always_comb begin
        unique case (leg_line)
            LEG_UPPER: begin
                target = 4'b1100; clr_mask = 4'b0011; trig_mask_n = 4'b1100;
            end
            LEG_LOWER: begin
                target = 4'b0011; clr_mask = 4'b1100; trig_mask_n = 4'b0011;
            end
            LEG_NEUTRAL: begin
                target = 4'b0110; clr_mask = 4'b1001; trig_mask_n = 4'b0110;
            end
            default: begin
                target = 4'b0000; clr_mask = 4'b1111; trig_mask_n = 4'b0000;
            end
        endcase
        trig = (gates & trig_mask_n) != trig_mask_n;
    end

    // Next-state evaluation: start a change, run the wait, then apply the target.
    always_comb begin
        gates_nx = gates;
        state_nx = state;
        count_nx = count;
        if (leg_line == LEG_OFF) begin
            gates_nx = '0;
        end else begin
            if (state_nx == SEQ_READY && trig) begin
                gates_nx = gates_nx & ~clr_mask;
                count_nx = dead_cycles;
                state_nx = SEQ_WAIT;
            end
            if (state_nx == SEQ_WAIT) begin
                if (count_nx != '0) begin
                    count_nx = count_nx - 1'b1;
                end else begin
                    state_nx = SEQ_READY;
                end
            end
            if (state_nx == SEQ_READY) begin
                gates_nx = target;
            end
        end
    end

    // State, counter and gate registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates <= '0;
            state <= SEQ_READY;
            count <= '0;
        end else begin
            gates <= gates_nx;
            state <= state_nx;
            count <= count_nx;
        end
    end
endmodule

// File: rtl/tl_leg_sequencer.sv
// Top of the three-level leg gate sequencer: comparator decode feeding the
// dead-time sequencer. Assumes inputs are synchronous to clk.
module tl_leg_sequencer
    import tl_leg_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] carrier_a,
    input  logic [CW-1:0] compare_a,
    input  logic [CW-1:0] carrier_b,
    input  logic [CW-1:0] compare_b,
    input  logic [DW-1:0] dead_cycles,
    output logic          gate_up_a,
    output logic          gate_up_b,
    output logic          gate_lo_a,
    output logic          gate_lo_b
);
    leg_line_e         leg_line;
    logic [GATE_N-1:0] gate_vec;
    seq_state_e        seq_state;
    logic [DW-1:0]     seq_count;
    logic              seq_in_wait;

    tl_leg_line_decode #(.CW(CW)) u_decode (
        .carrier_a (carrier_a),
        .compare_a (compare_a),
        .carrier_b (carrier_b),
        .compare_b (compare_b),
        .leg_line  (leg_line)
    );

    tl_leg_gate_seq #(.DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .leg_line    (leg_line),
        .dead_cycles (dead_cycles),
        .gates       (gate_vec),
        .state       (seq_state),
        .count       (seq_count)
    );

    assign seq_in_wait = (seq_state == SEQ_WAIT);
    assign {gate_up_a, gate_up_b, gate_lo_a, gate_lo_b} = gate_vec;
endmodule

// File: rtl/tl_leg_sequencer_chk.sv
// Property checker for tl_leg_sequencer, attached by bind below.
// Assumes access to the sequencer wait flag and counter of the top.
module tl_leg_sequencer_chk #(
    parameter int unsigned CW = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] carrier_a,
    input logic [CW-1:0] compare_a,
    input logic [CW-1:0] carrier_b,
    input logic [CW-1:0] compare_b,
    input logic [DW-1:0] dead_cycles,
    input logic          gate_up_a,
    input logic          gate_up_b,
    input logic          gate_lo_a,
    input logic          gate_lo_b,
    input logic          seq_in_wait,
    input logic [DW-1:0] seq_count
);
    logic off_in;
    logic [3:0] gv;
    assign off_in = (compare_a < carrier_a) && (compare_b > carrier_b);
    assign gv     = {gate_up_a, gate_up_b, gate_lo_a, gate_lo_b};

    p_pair_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_up_a && (gate_lo_a || gate_lo_b)) && !(gate_lo_b && (gate_up_a || gate_up_b)));

    p_off_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        off_in |=> (gv == 4'b0000));

    p_off_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        off_in |=> ($stable(seq_count) && $stable(seq_in_wait)));

    p_wait_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_in_wait && seq_count != '0 && !off_in) |=> (seq_in_wait && seq_count == $past(seq_count) - 1'b1));

    p_upper_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_up_a) && $past(dead_cycles) != '0) |-> !$past(gate_lo_a || gate_lo_b));

    p_lower_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo_b) && $past(dead_cycles) != '0) |-> !$past(gate_up_a || gate_up_b));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_in_wait && !off_in) ##1 seq_in_wait |-> $stable(gv));
endmodule

bind tl_leg_sequencer tl_leg_sequencer_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .carrier_a   (carrier_a),
    .compare_a   (compare_a),
    .carrier_b   (carrier_b),
    .compare_b   (compare_b),
    .dead_cycles (dead_cycles),
    .gate_up_a   (gate_up_a),
    .gate_up_b   (gate_up_b),
    .gate_lo_a   (gate_lo_a),
    .gate_lo_b   (gate_lo_b),
    .seq_in_wait (seq_in_wait),
    .seq_count   (seq_count)
);

// File: tb/tl_leg_sequencer_tb.sv
module tl_leg_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] carrier_a = '0, compare_a = '0, carrier_b = '0, compare_b = '0;
    logic [DW-1:0] dead_cycles = '0;
    logic          gate_up_a, gate_up_b, gate_lo_a, gate_lo_b;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state, built from the requirements
    logic [3:0] m_g = 4'b0000;
    bit         m_w = 1'b0;
    int         m_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tl_leg_sequencer #(.CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .carrier_a(carrier_a), .compare_a(compare_a),
        .carrier_b(carrier_b), .compare_b(compare_b),
        .dead_cycles(dead_cycles),
        .gate_up_a(gate_up_a), .gate_up_b(gate_up_b),
        .gate_lo_a(gate_lo_a), .gate_lo_b(gate_lo_b)
    );

    task automatic model_step();
        bit lt_a = compare_a < carrier_a;
        bit lt_b = compare_b < carrier_b;
        bit gt_a = compare_a > carrier_a;
        bit gt_b = compare_b > carrier_b;
        logic [3:0] tgt, dep;
        if (lt_a && gt_b) begin
            m_g = 4'b0000;             // R4: all off, state and counter kept
            return;
        end
        if (gt_a && gt_b) begin tgt = 4'b0011; dep = 4'b1100; end   // R3
        else              begin tgt = 4'b1100; dep = 4'b0011; end   // R2, R5
        if (!m_w && ((m_g & tgt) != tgt)) begin                     // R6 start
            m_g = m_g & ~dep;
            m_c = int'(dead_cycles);
            m_w = 1'b1;
        end
        if (m_w) begin
            if (m_c > 0) m_c = m_c - 1;
            else m_w = 1'b0;
        end
        if (!m_w) m_g = tgt;
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin m_g = 4'b0000; m_w = 1'b0; m_c = 0; end
        else model_step();
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act = {gate_up_a, gate_up_b, gate_lo_a, gate_lo_b};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gates=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // 0 upper, 1 lower, 2 off, 3 mixed relation (acts as upper)
    task automatic set_pat(input int p);
        case (p)
            0: begin carrier_a = 8'd9; compare_a = 8'd2; carrier_b = 8'd9; compare_b = 8'd3; end
            1: begin carrier_a = 8'd2; compare_a = 8'd9; carrier_b = 8'd3; compare_b = 8'd9; end
            2: begin carrier_a = 8'd9; compare_a = 8'd2; carrier_b = 8'd3; compare_b = 8'd9; end
            default: begin carrier_a = 8'd2; compare_a = 8'd9; carrier_b = 8'd9; compare_b = 8'd3; end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        set_pat(0);
        dead_cycles = 8'd3;
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 reset", 4'b0000);
        rst_n = 1'b1;

        // R6 / R2: first change from reset with D=3, on at 4th edge
        tick(); chk("R6 departing cleared", 4'b0000);
        tick(); chk("R6 wait", 4'b0000);
        tick(); chk("R6 wait", 4'b0000);
        tick(); chk("R2 upper on after D+1 edges", 4'b1100);
        // R9 hold
        for (int i = 0; i < 4; i++) begin tick(); chk("R9 hold", 4'b1100); end
        // R5 equality and mixed relation act as upper
        carrier_a = 8'd4; compare_a = 8'd4; carrier_b = 8'd4; compare_b = 8'd1;
        tick(); chk("R5 equality", 4'b1100);
        set_pat(3);
        tick(); chk("R5 mixed", 4'b1100);
        // R3 and R7: D=2 sampled, changed to 7 during wait
        set_pat(1); dead_cycles = 8'd2;
        tick(); chk("R6 upper cleared", 4'b0000);
        dead_cycles = 8'd7;
        tick(); chk("R7 wait", 4'b0000);
        tick(); chk("R7 lower on per sampled D", 4'b0011);
        tick(); chk("R3 lower held", 4'b0011);
        // R4 off from steady, then D=0 immediate return
        set_pat(2);
        tick(); chk("R4 off", 4'b0000);
        set_pat(1); dead_cycles = 8'd0;
        tick(); chk("R6 zero dead time", 4'b0011);
        // R4 off during a wait freezes the counter
        set_pat(0); dead_cycles = 8'd3;
        tick(); chk("R4 start", 4'b0000);
        set_pat(2);
        tick(); chk("R4 off in wait", 4'b0000);
        set_pat(0);
        tick(); chk("R4 resume", 4'b0000);
        tick(); chk("R4 resume", 4'b0000);
        tick(); chk("R4 resumed wait end", 4'b1100);
        // R10 pattern change during wait
        set_pat(1);
        tick(); chk("R10 start", 4'b0000);
        set_pat(0);
        tick(); chk("R10 wait", 4'b0000);
        tick(); chk("R10 wait", 4'b0000);
        tick(); chk("R10 follows current", 4'b1100);

        // Random segments checked against the model (R6, R8)
        for (int s = 0; s < 400; s++) begin
            int hold = 1 + int'($urandom_range(5));
            carrier_a = 8'($urandom_range(7));
            compare_a = 8'($urandom_range(7));
            carrier_b = 8'($urandom_range(7));
            compare_b = 8'($urandom_range(7));
            dead_cycles = 8'($urandom_range(4));
            for (int h = 0; h < hold; h++) begin
                tick();
                chk("R6 random vs model", m_g);
                n_chk++;
                if ((gate_up_a && (gate_lo_a || gate_lo_b)) || (gate_lo_b && (gate_up_a || gate_up_b))) begin
                    n_fail++;
                    $display("FAIL R8 overlap: gates=%b expected=no overlap",
                             {gate_up_a, gate_up_b, gate_lo_a, gate_lo_b});
                end
            end
        end
        // R1 reset again from an active state
        rst_n = 1'b0;
        tick(); chk("R1 reset mid-run", 4'b0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule